// File: doc/BRIEF.md
# Logarithmic Broadcast and Summation Tree

This block is the global communication network of a linear array of bit-serial processing elements whose count is a power of two. A binary tree of registered nodes connects the elements. Every node feeds at most two nodes below it, so no driver in the network sees a fan-out above two, and the path length grows with the logarithm of the element count.

Two kinds of transfer share the tree. A broadcast takes one bit from a chosen element, or from a bit injected at the root, and delivers it to every element. A reduction adds one unsigned value from every element and presents the total at the root. This is the vector sum that, for example, the backward pass of a neural network needs. An operation starts with a one-cycle start pulse. Its latency is fixed by the mode and the tree depth. A start that arrives while an operation is in flight is dropped.

Top module: `bcr_tree_net`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, busy, bcast_valid and sum_valid are all low.
- R2: Mode value 0 selects broadcast. With use_root low, when bcast_valid is high every bit of pe_bit_out equals pe_bit_in[src_idx] as sampled in the start cycle.
- R3: In a broadcast with use_root high, every bit of pe_bit_out equals root_bit_in as sampled in the start cycle, whatever pe_bit_in holds.
- R4: In a broadcast, bcast_valid is high for exactly one cycle, 2*(log2(N_PE)-1) cycles after the cycle in which start was accepted.
- R5: Mode value 1 selects reduction. Element i supplies pe_val_in[i*VAL_W +: VAL_W], unsigned. When sum_valid is high, sum_out (VAL_W+log2(N_PE) bits) equals the exact sum of all elements' values sampled in the start cycle, with no overflow even when every value is at its maximum.
- R6: In a reduction, sum_valid is high for exactly one cycle, log2(N_PE) cycles after the cycle in which start was accepted.
- R7: busy is high from the cycle after an accepted start up to and including the cycle in which that operation's valid output is high.
- R8: A start presented while busy is high is ignored. The operation in flight keeps its timing and its result, and no further operation follows.
- R9: Only the valid output that matches the accepted mode ever rises, and bcast_valid and sum_valid are never high together.
- R10: A start held high across operations is accepted in the first cycle in which busy is low, so operations follow each other with a gap of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests an operation; taken only when busy is low |
| mode | input | 1 | 0 = broadcast, 1 = reduction |
| src_idx | input | log2(N_PE) | Element index that sources a broadcast |
| use_root | input | 1 | 1 = broadcast root_bit_in instead of an element's bit |
| root_bit_in | input | 1 | Bit injected at the root for a broadcast |
| pe_bit_in | input | N_PE | One broadcast bit per element |
| pe_val_in | input | N_PE*VAL_W | One reduction value per element, element i at bits i*VAL_W upward |
| pe_bit_out | output | N_PE | Broadcast bit delivered to each element |
| bcast_valid | output | 1 | pe_bit_out holds the broadcast result this cycle |
| sum_out | output | VAL_W+log2(N_PE) | Reduction total at the root |
| sum_valid | output | 1 | sum_out holds the reduction result this cycle |
| busy | output | 1 | An operation is in flight |

## Verification
The assertions check on every clock that an accepted start loads the latency for its mode, that the countdown carries on unchanged when a start arrives while busy, that each valid lasts one cycle and never coincides with the other, and that all elements agree on the broadcast bit when bcast_valid is high. Whether the delivered bit is the one from the chosen element or from the root, whether the sum is numerically right at full scale, and whether results come from data captured in the start cycle rather than from later inputs can only be shown by the bench. Its scenarios compare the outputs against a behavioural model every cycle while they sweep the sources, root injection, extreme values, dropped starts and back-to-back starts.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

   typedef enum logic {
      MODE_BCAST  = 1'b0,
      MODE_REDUCE = 1'b1
   } net_mode_e;

   // register offset of the first node of tree level k (k >= 1) among the
   // N-2 intermediate nodes, counted from level 1 upward
   function automatic int node_off(input int n, input int k);
      return n - (n >> (k - 1));
   endfunction

   // offset of level m in the vector {intermediate regs, leaves}
   function automatic int kid_base(input int n, input int m);
      return 2 * n - 2 * (n >> m);
   endfunction

   // bit offset of level m in a packed vector whose level i holds
   // n>>i nodes of vw+i bits each
   function automatic int bit_off(input int n, input int vw, input int m);
      int acc;
      acc = 0;
      for (int i = 0; i < m; i++) acc += (n >> i) * (vw + i);
      return acc;
   endfunction

endpackage

// File: rtl/bcr_seq.sv
module bcr_seq
   import bcr_pkg::*;
#(
   parameter int BC_LAT = 4,
   parameter int RD_LAT = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  net_mode_e mode,
   output logic      accept,
   output logic      busy,
   output logic      bcast_valid,
   output logic      sum_valid
);

   localparam int MAX_LAT = (BC_LAT > RD_LAT) ? BC_LAT : RD_LAT;
   localparam int CNT_W   = $clog2(MAX_LAT + 1);

   if (BC_LAT < 1 || RD_LAT < 1) begin : g_chk_lat
      $error("bcr_seq: latencies must be at least one cycle");
   end

   logic [CNT_W-1:0] cnt;
   net_mode_e        mode_q;
   logic             last;

   assign busy   = (cnt != '0);
   assign accept = start & ~busy;
   assign last   = (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         mode_q <= MODE_BCAST;
      end else if (accept) begin
         cnt    <= (mode == MODE_REDUCE) ? CNT_W'(RD_LAT) : CNT_W'(BC_LAT);
         mode_q <= mode;
      end else if (busy) begin
         cnt    <= cnt - CNT_W'(1);
      end
   end

   assign bcast_valid = last & (mode_q == MODE_BCAST);
   assign sum_valid   = last & (mode_q == MODE_REDUCE);

   AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> cnt == (($past(mode) == MODE_REDUCE) ? CNT_W'(RD_LAT) : CNT_W'(BC_LAT))); // R4

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> cnt == $past(cnt) - CNT_W'(1)); // R8

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy); // R7

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_valid || sum_valid) |=> !(bcast_valid || sum_valid)); // R6

   AST_VALID_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bcast_valid && sum_valid)); // R9

endmodule

// File: rtl/bcr_bcast_tree.sv
module bcr_bcast_tree
   import bcr_pkg::*;
#(
   parameter  int N_PE  = 8,
   localparam int LVL   = $clog2(N_PE),
   localparam int IDX_W = LVL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             use_root,
   input  logic             root_bit_in,
   input  logic [IDX_W-1:0] src_idx,
   input  logic [N_PE-1:0]  pe_bit_in,
   output logic [N_PE-1:0]  pe_bit_out
);

   localparam int TOP_KID = kid_base(N_PE, LVL - 1);

   logic [N_PE-1:0]   leaf_g;   // leaves isolated except the source
   logic [N_PE-3:0]   up_r;     // rootward node registers
   logic [N_PE-3:0]   dn_r;     // leafward node registers
   logic [2*N_PE-3:0] up_all;
   logic              root_q;
   logic              use_root_q;
   logic              root_top;

   assign leaf_g = use_root ? '0 : (pe_bit_in & (N_PE'(1) << src_idx));
   assign up_all = {up_r, leaf_g};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root_q     <= 1'b0;
         use_root_q <= 1'b0;
      end else if (accept) begin
         root_q     <= root_bit_in;
         use_root_q <= use_root;
      end
   end

   // turnaround at the root is combinational
   assign root_top = use_root_q ? root_q : (up_all[TOP_KID] | up_all[TOP_KID+1]);

   for (genvar k = 1; k < LVL; k++) begin : g_lvl
      localparam int NN  = N_PE >> k;
      localparam int OFF = node_off(N_PE, k);
      localparam int KB  = kid_base(N_PE, k - 1);
      for (genvar j = 0; j < NN; j++) begin : g_node
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) up_r[OFF+j] <= 1'b0;
            else        up_r[OFF+j] <= up_all[KB+2*j] | up_all[KB+2*j+1];
         end
         if (k == LVL - 1) begin : g_top
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) dn_r[OFF+j] <= 1'b0;
               else        dn_r[OFF+j] <= root_top;
            end
         end else begin : g_mid
            localparam int POFF = node_off(N_PE, k + 1);
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) dn_r[OFF+j] <= 1'b0;
               else        dn_r[OFF+j] <= dn_r[POFF+j/2];
            end
         end
      end
   end

   for (genvar i = 0; i < N_PE; i++) begin : g_leaf
      assign pe_bit_out[i] = dn_r[i/2];
   end

endmodule

// File: rtl/bcr_sum_tree.sv
module bcr_sum_tree
   import bcr_pkg::*;
#(
   parameter  int N_PE       = 8,
   parameter  int VAL_W      = 8,
   parameter  bit SUM_SIGNED = 1'b0,
   localparam int LVL        = $clog2(N_PE),
   localparam int SUM_W      = VAL_W + LVL
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_PE*VAL_W-1:0] pe_val_in,
   output logic [SUM_W-1:0]      sum_out
);

   localparam int LEAF_BITS = N_PE * VAL_W;
   localparam int TOT       = bit_off(N_PE, VAL_W, LVL + 1);

   logic [TOT-LEAF_BITS-1:0] node_r;
   logic [TOT-1:0]           sum_all;

   assign sum_all = {node_r, pe_val_in};

   for (genvar k = 1; k <= LVL; k++) begin : g_lvl
      localparam int NN = N_PE >> k;
      localparam int W  = VAL_W + k;
      localparam int CW = W - 1;
      localparam int PB = bit_off(N_PE, VAL_W, k - 1);
      localparam int MB = bit_off(N_PE, VAL_W, k) - LEAF_BITS;
      for (genvar j = 0; j < NN; j++) begin : g_node
         logic [CW-1:0] a_w;
         logic [CW-1:0] b_w;
         logic [W-1:0]  s_w;
         assign a_w = sum_all[PB+(2*j)*CW +: CW];
         assign b_w = sum_all[PB+(2*j+1)*CW +: CW];
         if (SUM_SIGNED) begin : g_sext
            assign s_w = {a_w[CW-1], a_w} + {b_w[CW-1], b_w};
         end else begin : g_zext
            assign s_w = {1'b0, a_w} + {1'b0, b_w};
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) node_r[MB+j*W +: W] <= '0;
            else        node_r[MB+j*W +: W] <= s_w;
         end
      end
   end

   assign sum_out = sum_all[bit_off(N_PE, VAL_W, LVL) +: SUM_W];

endmodule

// File: rtl/bcr_tree_net.sv
module bcr_tree_net
   import bcr_pkg::*;
#(
   parameter  int N_PE       = 8,
   parameter  int VAL_W      = 8,
   parameter  bit SUM_SIGNED = 1'b0,
   localparam int LVL        = $clog2(N_PE),
   localparam int SUM_W      = VAL_W + LVL
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  mode,
   input  logic [LVL-1:0]        src_idx,
   input  logic                  use_root,
   input  logic                  root_bit_in,
   input  logic [N_PE-1:0]       pe_bit_in,
   input  logic [N_PE*VAL_W-1:0] pe_val_in,
   output logic [N_PE-1:0]       pe_bit_out,
   output logic                  bcast_valid,
   output logic [SUM_W-1:0]      sum_out,
   output logic                  sum_valid,
   output logic                  busy
);

   localparam int BC_LAT = 2 * (LVL - 1);
   localparam int RD_LAT = LVL;

   if (N_PE < 4 || (N_PE & (N_PE - 1)) != 0) begin : g_chk_n
      $error("bcr_tree_net: N_PE must be a power of two of at least 4");
   end
   if (VAL_W < 1) begin : g_chk_w
      $error("bcr_tree_net: VAL_W must be positive");
   end

   logic accept;

   bcr_seq #(
      .BC_LAT (BC_LAT),
      .RD_LAT (RD_LAT)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mode        (net_mode_e'(mode)),
      .accept      (accept),
      .busy        (busy),
      .bcast_valid (bcast_valid),
      .sum_valid   (sum_valid)
   );

   bcr_bcast_tree #(
      .N_PE (N_PE)
   ) i_bcast (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .use_root    (use_root),
      .root_bit_in (root_bit_in),
      .src_idx     (src_idx),
      .pe_bit_in   (pe_bit_in),
      .pe_bit_out  (pe_bit_out)
   );

   bcr_sum_tree #(
      .N_PE       (N_PE),
      .VAL_W      (VAL_W),
      .SUM_SIGNED (SUM_SIGNED)
   ) i_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .pe_val_in (pe_val_in),
      .sum_out   (sum_out)
   );

   AST_LEAVES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid |-> (pe_bit_out == {N_PE{pe_bit_out[0]}})); // R2

endmodule

// File: tb/test_bcr_tree_net.sv
module test_bcr_tree_net;

   localparam int N      = 8;
   localparam int VW     = 8;
   localparam int LV     = 3;
   localparam int SW     = VW + LV;
   localparam int BC_LAT = 2 * (LV - 1);
   localparam int RD_LAT = LV;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          mode;
   logic [LV-1:0] src_idx;
   logic          use_root;
   logic          root_bit_in;
   logic [N-1:0]  pe_bit_in;
   logic [N*VW-1:0] pe_val_in;
   logic [N-1:0]  pe_bit_out;
   logic          bcast_valid;
   logic [SW-1:0] sum_out;
   logic          sum_valid;
   logic          busy;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;
   string tag   = "R1";

   // reference model state
   int m_cnt  = 0;
   bit m_mode = 1'b0;
   bit m_bit  = 1'b0;
   int m_sum  = 0;

   always #5 clk = ~clk;

   bcr_tree_net i_bcr_tree_net (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .src_idx(src_idx),
      .use_root(use_root), .root_bit_in(root_bit_in), .pe_bit_in(pe_bit_in),
      .pe_val_in(pe_val_in), .pe_bit_out(pe_bit_out), .bcast_valid(bcast_valid),
      .sum_out(sum_out), .sum_valid(sum_valid), .busy(busy)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s (%s) %s act=%0d exp=%0d t=%0t", req, tag, what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         m_cnt = 0;
      end else if (start && m_cnt == 0) begin
         m_mode = mode;
         m_cnt  = mode ? RD_LAT : BC_LAT;
         m_bit  = use_root ? root_bit_in : pe_bit_in[src_idx];
         m_sum  = 0;
         for (int i = 0; i < N; i++) m_sum += int'(pe_val_in[i*VW +: VW]);
      end else if (m_cnt > 0) begin
         m_cnt--;
      end
   endtask

   task automatic compare();
      bit ev;
      ev = (m_cnt == 1);
      chk("R7", "busy", longint'(busy), longint'(m_cnt != 0));
      chk("R4", "bcast_valid", longint'(bcast_valid), longint'(ev && !m_mode));
      chk("R6", "sum_valid", longint'(sum_valid), longint'(ev && m_mode));
      if (ev && !m_mode)
         chk(use_root ? "R3" : "R2", "pe_bit_out", longint'(pe_bit_out), longint'({N{m_bit}}));
      if (ev && m_mode)
         chk("R5", "sum_out", longint'(sum_out), longint'(m_sum));
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic scramble();
      pe_bit_in   = N'($urandom);
      root_bit_in = 1'($urandom);
      for (int i = 0; i < N; i++) pe_val_in[i*VW +: VW] = VW'($urandom);
   endtask

   // one operation; inputs change right after the start cycle
   task automatic run_op(input bit md, input int src, input bit rt);
      mode     = md;
      src_idx  = LV'(src);
      use_root = rt;
      start    = 1'b1;
      step();
      start    = 1'b0;
      scramble();
      use_root = ~rt;
      src_idx  = ~src_idx;
      for (int c = 0; c < BC_LAT + 1; c++) step();
      use_root = rt;
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; mode = 1'b0; src_idx = '0; use_root = 1'b0;
      root_bit_in = 1'b0; pe_bit_in = '0; pe_val_in = '0;

      // R1: reset state
      tag = "R1";
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk("R1", "busy in reset", longint'(busy), 0);
         chk("R1", "bcast_valid in reset", longint'(bcast_valid), 0);
         chk("R1", "sum_valid in reset", longint'(sum_valid), 0);
      end
      rst_n = 1'b1;
      step();
      chk("R1", "busy after reset", longint'(busy), 0);

      // R2: broadcast from every element, bit 1 then bit 0 at the source
      tag = "R2";
      for (int s = 0; s < N; s++) begin
         pe_bit_in = N'(1) << s;
         run_op(1'b0, s, 1'b0);
         pe_bit_in = ~(N'(1) << s);
         run_op(1'b0, s, 1'b0);
      end

      // R3: root injection ignores element bits
      tag = "R3";
      pe_bit_in = '1; root_bit_in = 1'b0;
      run_op(1'b0, 2, 1'b1);
      pe_bit_in = '0; root_bit_in = 1'b1;
      run_op(1'b0, 6, 1'b1);

      // R5: reduction at full scale, zero and random
      tag = "R5";
      pe_val_in = '1;
      run_op(1'b1, 0, 1'b0);
      pe_val_in = '0;
      run_op(1'b1, 0, 1'b0);
      for (int r = 0; r < 4; r++) begin
         scramble();
         run_op(1'b1, 0, 1'b0);
      end

      // R9: alternating modes
      tag = "R9";
      for (int r = 0; r < 4; r++) begin
         scramble();
         run_op(r[0], r + 3, 1'b0);
      end

      // R8: starts while busy are dropped
      tag = "R8";
      scramble();
      mode = 1'b0; src_idx = 3'd5; use_root = 1'b0; start = 1'b1;
      step();
      for (int c = 0; c < BC_LAT - 1; c++) begin
         mode = 1'b1; scramble(); src_idx = LV'(c);
         step();
      end
      start = 1'b0;
      for (int c = 0; c < BC_LAT + 2; c++) step();
      chk("R8", "idle after dropped starts", longint'(busy), 0);

      // R10: start held high, operations back to back
      tag = "R10";
      start = 1'b1;
      for (int c = 0; c < 24; c++) begin
         mode = (c >= 12);
         scramble();
         src_idx = LV'(c);
         step();
      end
      start = 1'b0;
      for (int c = 0; c < BC_LAT + 2; c++) step();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule